// File: doc/BRIEF.md
# Byte Effective Address Generator

This block forms the memory address of a byte-wide destination operand for a processor with 32-bit address registers. It is given the addressing-mode code of the current instruction, the value of the pointer register named by the instruction, a wide field that holds either a displacement or an absolute address, an 8-bit short-absolute field and a short-base register. From these it produces the access address, the new pointer value and a strobe that says whether the pointer register is to be rewritten.

The auto-modify modes step the pointer by one byte, either before the access (pre) or after it (post). Displacement modes add a sign-extended 16-bit or a full 32-bit offset to the pointer. Absolute modes use the field itself, and the short-absolute mode adds the 8-bit field to the short-base register. When the byte source of a register-to-memory add is the low byte of the pointer being stepped, the block substitutes the stepped value so that the ALU sees the updated byte.

The block has no clock. Every output follows its inputs within the same cycle, so it sits between operand decode and the memory request stage.

Top module: `byte_ea_gen`

## Requirements
- R1: Mode code 0 (indirect) gives address equal to the pointer value, with no write-back.
- R2: Mode codes 1 (post-step up) and 2 (post-step down) give address equal to the original pointer, assert write-back, and give a new pointer value of pointer plus 1 or pointer minus 1.
- R3: Mode codes 3 (pre-step up) and 4 (pre-step down) give a new pointer value of pointer plus 1 or minus 1, assert write-back, and use that new value as the address.
- R4: Mode code 5 gives pointer plus bits 15:0 of the wide field sign-extended to 32 bits; bits 31:16 of the field have no effect.
- R5: Mode code 6 gives pointer plus the full 32-bit wide field.
- R6: Mode code 7 gives short-base plus the 8-bit short field taken as unsigned.
- R7: Mode code 8 gives bits 15:0 of the wide field sign-extended to 32 bits as the address; mode code 9 gives the whole wide field.
- R8: Write-back enable is high only for mode codes 1 to 4; whenever it is low the new-pointer output equals the pointer input.
- R9: All address and pointer arithmetic wraps modulo 2^32 (0xFFFFFFFF plus 1 is 0, 0 minus 1 is 0xFFFFFFFF).
- R10: Unused mode codes 10 to 15 behave as indirect mode (R1).
- R11: The source selector has bit 3 set for a low byte and bits 2:0 as register number; when the mode is 1 to 4, bit 3 is set and bits 2:0 equal the pointer number, the source output is bits 7:0 of the new pointer value; otherwise it equals the source byte input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_code | input | 4 | Addressing-mode code |
| ptr_val | input | 32 | Current pointer register value |
| ptr_num | input | 3 | Number of the pointer register |
| wide_field | input | 32 | Displacement or absolute field |
| short_field | input | 8 | Short-absolute field |
| short_base | input | 32 | Base register for short-absolute mode |
| src_sel | input | 4 | Byte source selector (bit 3 low byte, bits 2:0 register) |
| src_byte | input | 8 | Byte source value read from the register file |
| eff_addr | output | 32 | Effective address of the access |
| ptr_wr_en | output | 1 | Pointer write-back enable |
| ptr_next | output | 32 | Pointer value to write back |
| src_fwd | output | 8 | Byte source value after forwarding |

## Verification
All outputs are combinational, so every result is due in the same cycle as the stimulus that causes it. The bench applies each input set on a falling clock edge and compares all four outputs one time unit after the next rising edge, long after the inputs settled and away from the edge at which stimulus changes. The sweep covers all sixteen mode codes against pointer values at both wrap boundaries, fields with either sign in the low half and stray upper bits, and source selectors that do and do not alias the stepped pointer.

// File: rtl/bea_pkg.sv
package bea_pkg;

    localparam int ADDR_W    = 32;
    localparam int SHORT_W   = 8;
    localparam int HALF_W    = 16;
    localparam int REGNUM_W  = 3;
    localparam int BYTE_STEP = 1;

    typedef enum logic [3:0] {
        AM_IND     = 4'd0,
        AM_POSTUP  = 4'd1,
        AM_POSTDN  = 4'd2,
        AM_PREUP   = 4'd3,
        AM_PREDN   = 4'd4,
        AM_DISP16  = 4'd5,
        AM_DISP32  = 4'd6,
        AM_SHORT   = 4'd7,
        AM_ABS16   = 4'd8,
        AM_ABS32   = 4'd9
    } am_e;

    typedef enum logic [1:0] {
        BASE_PTR   = 2'd0,
        BASE_SHORT = 2'd1,
        BASE_ZERO  = 2'd2
    } base_sel_e;

    typedef enum logic [1:0] {
        OFF_NONE = 2'd0,
        OFF_HALF = 2'd1,
        OFF_FULL = 2'd2,
        OFF_U8   = 2'd3
    } off_sel_e;

    typedef struct packed {
        logic      auto_mod;
        logic      addr_new;
        logic      step_down;
        base_sel_e base_sel;
        off_sel_e  off_sel;
    } am_ctrl_t;

    function automatic logic [ADDR_W-1:0] sext_half(input logic [ADDR_W-1:0] f);
        return {{(ADDR_W-HALF_W){f[HALF_W-1]}}, f[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/bea_mode_dec.sv
module bea_mode_dec
    import bea_pkg::*;
(
    input  logic [3:0] mode_code,
    output am_ctrl_t   ctrl
);
    always_comb begin
        ctrl = '{auto_mod: 1'b0, addr_new: 1'b0, step_down: 1'b0,
                 base_sel: BASE_PTR, off_sel: OFF_NONE};
        case (mode_code)
            AM_POSTUP: ctrl.auto_mod = 1'b1;
            AM_POSTDN: begin
                ctrl.auto_mod  = 1'b1;
                ctrl.step_down = 1'b1;
            end
            AM_PREUP: begin
                ctrl.auto_mod = 1'b1;
                ctrl.addr_new = 1'b1;
            end
            AM_PREDN: begin
                ctrl.auto_mod  = 1'b1;
                ctrl.addr_new  = 1'b1;
                ctrl.step_down = 1'b1;
            end
            AM_DISP16: ctrl.off_sel = OFF_HALF;
            AM_DISP32: ctrl.off_sel = OFF_FULL;
            AM_SHORT: begin
                ctrl.base_sel = BASE_SHORT;
                ctrl.off_sel  = OFF_U8;
            end
            AM_ABS16: begin
                ctrl.base_sel = BASE_ZERO;
                ctrl.off_sel  = OFF_HALF;
            end
            AM_ABS32: begin
                ctrl.base_sel = BASE_ZERO;
                ctrl.off_sel  = OFF_FULL;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bea_addr_path.sv
module bea_addr_path
    import bea_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int SW    = SHORT_W,
    parameter int STEP  = BYTE_STEP
) (
    input  am_ctrl_t        ctrl,
    input  logic [AW-1:0]   ptr_val,
    input  logic [AW-1:0]   wide_field,
    input  logic [SW-1:0]   short_field,
    input  logic [AW-1:0]   short_base,
    output logic [AW-1:0]   addr,
    output logic [AW-1:0]   stepped
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] base_op;
    logic [AW-1:0] off_op;
    logic [AW-1:0] sum;

    always_comb begin
        case (ctrl.base_sel)
            BASE_SHORT: base_op = short_base;
            BASE_ZERO:  base_op = '0;
            default:    base_op = ptr_val;
        endcase
        case (ctrl.off_sel)
            OFF_HALF: off_op = sext_half(wide_field);
            OFF_FULL: off_op = wide_field;
            OFF_U8:   off_op = {{(AW-SW){1'b0}}, short_field};
            default:  off_op = '0;
        endcase
        sum     = base_op + off_op;
        stepped = ctrl.step_down ? (ptr_val - STEP_V) : (ptr_val + STEP_V);
        addr    = ctrl.addr_new ? stepped : sum;
    end
endmodule

// File: rtl/bea_src_fwd.sv
module bea_src_fwd
    import bea_pkg::*;
#(
    parameter int RW = REGNUM_W
) (
    input  logic          auto_mod,
    input  logic [RW:0]   src_sel,
    input  logic [RW-1:0] ptr_num,
    input  logic [7:0]    src_byte,
    input  logic [7:0]    new_low,
    output logic [7:0]    src_fwd
);
    logic alias_hit;

    always_comb begin
        alias_hit = auto_mod && src_sel[RW] && (src_sel[RW-1:0] == ptr_num);
        src_fwd   = alias_hit ? new_low : src_byte;
    end
endmodule

// File: rtl/byte_ea_gen.sv
module byte_ea_gen
    import bea_pkg::*;
(
    input  logic [3:0]          mode_code,
    input  logic [ADDR_W-1:0]   ptr_val,
    input  logic [REGNUM_W-1:0] ptr_num,
    input  logic [ADDR_W-1:0]   wide_field,
    input  logic [SHORT_W-1:0]  short_field,
    input  logic [ADDR_W-1:0]   short_base,
    input  logic [REGNUM_W:0]   src_sel,
    input  logic [7:0]          src_byte,
    output logic [ADDR_W-1:0]   eff_addr,
    output logic                ptr_wr_en,
    output logic [ADDR_W-1:0]   ptr_next,
    output logic [7:0]          src_fwd
);
    am_ctrl_t          ctrl;
    logic [ADDR_W-1:0] stepped;

    bea_mode_dec u_dec (
        .mode_code (mode_code),
        .ctrl      (ctrl)
    );

    bea_addr_path #(.AW(ADDR_W), .SW(SHORT_W), .STEP(BYTE_STEP)) u_path (
        .ctrl        (ctrl),
        .ptr_val     (ptr_val),
        .wide_field  (wide_field),
        .short_field (short_field),
        .short_base  (short_base),
        .addr        (eff_addr),
        .stepped     (stepped)
    );

    always_comb begin
        ptr_wr_en = ctrl.auto_mod;
        ptr_next  = ctrl.auto_mod ? stepped : ptr_val;
    end

    bea_src_fwd #(.RW(REGNUM_W)) u_fwd (
        .auto_mod (ctrl.auto_mod),
        .src_sel  (src_sel),
        .ptr_num  (ptr_num),
        .src_byte (src_byte),
        .new_low  (ptr_next[7:0]),
        .src_fwd  (src_fwd)
    );

    always_comb begin
        // R8
        wb_only_auto_chk: assert (!ptr_wr_en || (mode_code >= 4'd1 && mode_code <= 4'd4));
        // R8
        wb_hold_chk: assert (ptr_wr_en || ptr_next == ptr_val);
        // R2
        post_addr_chk: assert (!(mode_code == 4'd1 || mode_code == 4'd2) || eff_addr == ptr_val);
        // R3
        pre_addr_chk: assert (!(mode_code == 4'd3 || mode_code == 4'd4) || eff_addr == ptr_next);
        // R9
        step_size_chk: assert (!ptr_wr_en || (ptr_next - ptr_val == 32'd1) || (ptr_val - ptr_next == 32'd1));
        // R11
        fwd_only_alias_chk: assert (src_fwd == src_byte || (ptr_wr_en && src_sel[REGNUM_W]));
    end
endmodule

// File: tb/sim_byte_ea_gen.sv
module sim_byte_ea_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [3:0]  mode_code;
    logic [31:0] ptr_val, wide_field, short_base;
    logic [2:0]  ptr_num;
    logic [7:0]  short_field, src_byte;
    logic [3:0]  src_sel;
    logic [31:0] eff_addr, ptr_next;
    logic        ptr_wr_en;
    logic [7:0]  src_fwd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_ea_gen u0 (
        .mode_code(mode_code), .ptr_val(ptr_val), .ptr_num(ptr_num),
        .wide_field(wide_field), .short_field(short_field), .short_base(short_base),
        .src_sel(src_sel), .src_byte(src_byte),
        .eff_addr(eff_addr), .ptr_wr_en(ptr_wr_en), .ptr_next(ptr_next), .src_fwd(src_fwd)
    );

    function automatic string mode_req(input int m);
        case (m)
            0: return "R1";
            1, 2: return "R2";
            3, 4: return "R3";
            5: return "R4";
            6: return "R5";
            7: return "R6";
            8, 9: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply_and_check(input int m, input logic [31:0] b, input logic [31:0] f,
                                   input logic [7:0] s8, input logic [31:0] sb,
                                   input logic [2:0] pn, input logic [3:0] ss, input logic [7:0] sv);
        logic [31:0] e_addr, e_next;
        logic        e_wr;
        logic [7:0]  e_src;
        logic [31:0] sx;
        sx = {{16{f[15]}}, f[15:0]};
        e_wr = (m >= 1 && m <= 4);
        e_next = b;
        case (m)
            1: begin e_next = b + 32'd1; e_addr = b; end
            2: begin e_next = b - 32'd1; e_addr = b; end
            3: begin e_next = b + 32'd1; e_addr = e_next; end
            4: begin e_next = b - 32'd1; e_addr = e_next; end
            5: e_addr = b + sx;
            6: e_addr = b + f;
            7: e_addr = sb + {24'd0, s8};
            8: e_addr = sx;
            9: e_addr = f;
            default: e_addr = b;
        endcase
        e_src = (e_wr && ss[3] && ss[2:0] == pn) ? e_next[7:0] : sv;

        @(negedge clk);
        mode_code = 4'(m); ptr_val = b; wide_field = f; short_field = s8;
        short_base = sb; ptr_num = pn; src_sel = ss; src_byte = sv;
        @(posedge clk);
        #1;
        chk(mode_req(m), "eff_addr", eff_addr, e_addr);
        chk("R8", "ptr_wr_en", {31'd0, ptr_wr_en}, {31'd0, e_wr});
        chk(e_wr ? mode_req(m) : "R8", "ptr_next", ptr_next, e_next);
        chk("R11", "src_fwd", {24'd0, src_fwd}, {24'd0, e_src});
    endtask

    initial begin
        logic [31:0] bases [4];
        logic [31:0] fields [4];
        bases  = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_1000, 32'h8000_00F0};
        fields = '{32'h0000_FFFF, 32'h1234_0001, 32'hABCD_8000, 32'hFFFF_FFFF};

        // Quiet inputs: indirect mode, zero pointer, no write-back (R1, R8)
        apply_and_check(0, 32'd0, 32'd0, 8'd0, 32'd0, 3'd0, 4'd0, 8'd0);

        // Wrap boundaries (R9)
        apply_and_check(1, 32'hFFFF_FFFF, 32'd0, 8'd0, 32'd0, 3'd0, 4'd0, 8'h11);
        chk("R9", "post-up wrap", ptr_next, 32'h0000_0000);
        apply_and_check(4, 32'h0000_0000, 32'd0, 8'd0, 32'd0, 3'd0, 4'd0, 8'h11);
        chk("R9", "pre-down wrap", eff_addr, 32'hFFFF_FFFF);

        // Short-absolute: base X-100 with field 100 reaches X (R6)
        apply_and_check(7, 32'd0, 32'd0, 8'd100, 32'h0000_2000 - 32'd100, 3'd0, 4'd0, 8'd0);
        chk("R6", "short abs hit", eff_addr, 32'h0000_2000);

        // Aliased source byte after pre-step down (R11)
        apply_and_check(4, 32'h0000_0500, 32'd0, 8'd0, 32'd0, 3'd2, 4'hA, 8'h77);
        chk("R11", "alias low byte", {24'd0, src_fwd}, 32'h0000_00FF);

        for (int m = 0; m < 16; m++)
            for (int bi = 0; bi < 4; bi++)
                for (int fi = 0; fi < 4; fi++)
                    for (int si = 0; si < 3; si++) begin
                        logic [3:0] ss;
                        case (si)
                            0: ss = 4'b1011;
                            1: ss = 4'b0011;
                            default: ss = 4'b1101;
                        endcase
                        apply_and_check(m, bases[bi], fields[fi], 8'(8'hC3 + fi),
                                        32'hFFFF_FF80 + 32'(bi), 3'd3, ss, 8'(8'h5A ^ si));
                    end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before sweep ended");
        end
        #(CLK_PERIOD);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule